// File: doc/BRIEF.md
# PAL Line-Drop Row Selector

This block sits between a video sync front end and the row driver of a 234-row panel. It counts incoming lines from the start of each field and decides, line by line, whether the line is written to the panel. A PAL field carries 273 candidate picture lines, which is more than the panel holds. The block therefore discards 39 of them in a periodic pattern. The pattern repeats every 14 lines, and its phase depends on whether the current field is odd or even. This spreads the loss evenly over the picture height instead of cutting off the top or bottom.

Outside PAL mode the block keeps a contiguous window of 234 lines and drops nothing else. For each kept line it raises a one-cycle valid pulse and presents the panel row index. The index starts at zero each field and advances only on kept lines. It saturates at the last panel row, and once that row has been written no further lines are marked valid. Sync extraction and pixel sampling are handled elsewhere.

Top module: `pal_line_selector`

## Requirements
- R1: After reset `line_valid` is 0 and `row` is 0.
- R2: A `field_stb` pulse restarts line numbering, so the first `line_stb` after it is line 1. It also clears `row` to 0. When `field_stb` and `line_stb` are high in the same cycle, `field_stb` wins and that line is neither counted nor kept.
- R3: `odd_field` (1 = odd field) and `pal_mode` (1 = PAL) are captured when `field_stb` is high. Changes to these inputs during the field have no effect until the next field start.
- R4: In PAL mode only lines 26 to 298 inclusive can be kept.
- R5: In a PAL even field, lines 14n+12 and 14n+20 for n = 1..20 are dropped. This leaves exactly 234 kept lines.
- R6: In a PAL odd field, lines 14n+17 and 14n+23 for n = 1..20 are dropped. This leaves exactly 234 kept lines.
- R7: In non-PAL mode every line from 20 to 253 inclusive is kept, and no other line is kept.
- R8: `line_valid` is a one-cycle pulse in the cycle after the `line_stb` of a kept line. During that pulse `row` holds the line's row index. Indices run 0, 1, 2, … over the kept lines of a field. `row` changes only after a strobe.
- R9: `row` never exceeds ROWS-1. After row ROWS-1 has been written, no further line in that field is marked valid, and `row` stays at ROWS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pal_mode | input | 1 | 1 = PAL drop pattern, 0 = plain window; captured at field start |
| odd_field | input | 1 | 1 = odd field; captured at field start |
| field_stb | input | 1 | One-cycle pulse at the start of a field |
| line_stb | input | 1 | One-cycle pulse per incoming line |
| line_valid | output | 1 | One-cycle pulse marking a kept line |
| row | output | $clog2(ROWS) | Panel row index of the kept line |

## Verification
The hardest state to reach is row saturation. With the default 234 rows, every mode keeps exactly 234 lines, so the limit is met but never exceeded. The bench therefore runs a second instance with a 100-row panel next to the default one, on the same stimulus. A full non-PAL field then drives that instance past its last row, while the default instance checks the complete window. Mid-field restarts, with `field_stb` and `line_stb` coinciding, and mid-field changes of the parity and mode inputs cover the capture and priority rules.

// File: rtl/pal_line_selector.sv
module pal_line_selector #(
  parameter int ROWS      = 234,
  parameter int LINE_W    = 10,
  parameter int PAL_FIRST = 26,
  parameter int PAL_LAST  = 298,
  parameter int STD_FIRST = 20,
  parameter int STD_LAST  = 253,
  parameter int PERIOD    = 14,
  parameter int N_LO      = 1,
  parameter int N_HI      = 20,
  parameter int EVEN_A    = 12,
  parameter int EVEN_B    = 20,
  parameter int ODD_A     = 17,
  parameter int ODD_B     = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pal_mode,
  input  logic                    odd_field,
  input  logic                    field_stb,
  input  logic                    line_stb,
  output logic                    line_valid,
  output logic [$clog2(ROWS)-1:0] row
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int PH_W  = $clog2(PERIOD);

  logic [LINE_W-1:0] lnum, blk;
  logic [PH_W-1:0]   ph;
  logic [ROW_W-1:0]  wr_row;
  logic              full, odd_q, pal_q;
  logic              in_rng, drop, keep;

  function automatic logic hit(input int off, input logic [PH_W-1:0] p,
                               input logic [LINE_W-1:0] b);
    return (int'(p) == off % PERIOD) &&
           (int'(b) >= N_LO + off / PERIOD) &&
           (int'(b) <= N_HI + off / PERIOD);
  endfunction

  assign in_rng = pal_q ? (lnum >= LINE_W'(PAL_FIRST) && lnum <= LINE_W'(PAL_LAST))
                        : (lnum >= LINE_W'(STD_FIRST) && lnum <= LINE_W'(STD_LAST));
  assign drop   = pal_q && (odd_q ? (hit(ODD_A, ph, blk)  || hit(ODD_B, ph, blk))
                                  : (hit(EVEN_A, ph, blk) || hit(EVEN_B, ph, blk)));
  assign keep   = in_rng && !drop && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lnum       <= LINE_W'(1);
      ph         <= PH_W'(1);
      blk        <= '0;
      wr_row     <= '0;
      full       <= 1'b0;
      odd_q      <= 1'b0;
      pal_q      <= 1'b0;
      line_valid <= 1'b0;
      row        <= '0;
    end else begin
      line_valid <= 1'b0;
      if (field_stb) begin
        lnum   <= LINE_W'(1);
        ph     <= PH_W'(1);
        blk    <= '0;
        wr_row <= '0;
        full   <= 1'b0;
        odd_q  <= odd_field;
        pal_q  <= pal_mode;
        row    <= '0;
      end else if (line_stb) begin
        if (lnum != '1) begin
          lnum <= lnum + 1'b1;
          if (ph == PH_W'(PERIOD - 1)) begin
            ph  <= '0;
            blk <= blk + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        if (keep) begin
          line_valid <= 1'b1;
          row        <= wr_row;
          if (wr_row == ROW_W'(ROWS - 1)) full <= 1'b1;
          else                            wr_row <= wr_row + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pal_line_selector_chk.sv
module pal_line_selector_chk #(
  parameter int ROWS = 234
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    field_stb,
  input logic                    line_stb,
  input logic                    line_valid,
  input logic [$clog2(ROWS)-1:0] row
);
  localparam int ROW_W = $clog2(ROWS);

  // R9
  row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row <= ROW_W'(ROWS - 1));

  // R8
  valid_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> ($past(line_stb) && !$past(field_stb)));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && !line_stb) |=> !line_valid);

  // R8
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_stb && !field_stb) |=> $stable(row));

  // R2
  field_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_stb |=> (!line_valid && row == '0));
endmodule

bind pal_line_selector pal_line_selector_chk #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .line_stb(line_stb),
  .line_valid(line_valid), .row(row)
);

// File: tb/pal_line_selector_bench.sv
module pal_line_selector_bench;
  localparam int SMALL = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pal_mode = 1'b0, odd_field = 1'b0, field_stb = 1'b0, line_stb = 1'b0;
  logic       v_main, v_small;
  logic [7:0] r_main;
  logic [6:0] r_small;
  int checks = 0, fails = 0, cycles = 0;
  int erow_m, erow_s, last_m, last_s, kept_m;

  always #4 clk = ~clk;

  pal_line_selector u_pal_line_selector (
    .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .odd_field(odd_field),
    .field_stb(field_stb), .line_stb(line_stb), .line_valid(v_main), .row(r_main));

  pal_line_selector #(.ROWS(SMALL)) u_small (
    .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .odd_field(odd_field),
    .field_stb(field_stb), .line_stb(line_stb), .line_valid(v_small), .row(r_small));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_keep(input int l, input bit pal, input bit odd);
    if (!pal) return (l >= 20 && l <= 253);
    if (l < 26 || l > 298) return 1'b0;
    for (int n = 1; n <= 20; n++) begin
      if (odd  && (l == 14*n + 17 || l == 14*n + 23)) return 1'b0;
      if (!odd && (l == 14*n + 12 || l == 14*n + 20)) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic start_field(input bit pal, input bit odd, input bit with_line);
    @(negedge clk);
    field_stb = 1'b1; line_stb = with_line; pal_mode = pal; odd_field = odd;
    @(negedge clk);
    field_stb = 1'b0; line_stb = 1'b0;
    chk(v_main == 1'b0, "R2 valid after field start", int'(v_main), 0);
    chk(r_main == 8'd0, "R2 row after field start", int'(r_main), 0);
    erow_m = 0; erow_s = 0; last_m = 0; last_s = 0; kept_m = 0;
  endtask

  task automatic line_and_check(input int l, input bit pal, input bit odd, input string tag);
    bit k;
    @(negedge clk); line_stb = 1'b1;
    @(negedge clk); line_stb = 1'b0;
    k = exp_keep(l, pal, odd);
    chk(v_main == (k && erow_m < 234), tag, int'(v_main), int'(k && erow_m < 234));
    if (k && erow_m < 234) begin
      chk(int'(r_main) == erow_m, "R8 row index", int'(r_main), erow_m);
      last_m = erow_m; erow_m++; kept_m++;
    end else chk(int'(r_main) == last_m, "R8 row hold", int'(r_main), last_m);
    chk(v_small == (k && erow_s < SMALL), "R9 small valid", int'(v_small), int'(k && erow_s < SMALL));
    if (k && erow_s < SMALL) begin
      chk(int'(r_small) == erow_s, "R9 small row", int'(r_small), erow_s);
      last_s = erow_s; erow_s++;
    end else chk(int'(r_small) == last_s, "R9 small row hold", int'(r_small), last_s);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(v_main == 1'b0, "R1 valid", int'(v_main), 0);
    chk(r_main == 8'd0, "R1 row", int'(r_main), 0);
  endtask

  task automatic t_field(input bit pal, input bit odd, input int nlines, input string tag);
    start_field(pal, odd, 1'b0);
    for (int l = 1; l <= nlines; l++) line_and_check(l, pal, odd, tag);
    chk(kept_m == 234, {tag, " kept count"}, kept_m, 234);
  endtask

  task automatic t_latch;
    start_field(1'b1, 1'b1, 1'b0);
    pal_mode = 1'b0; odd_field = 1'b0;
    for (int l = 1; l <= 60; l++) line_and_check(l, 1'b1, 1'b1, "R3 captured mode");
  endtask

  task automatic t_restart;
    start_field(1'b0, 1'b0, 1'b0);
    for (int l = 1; l <= 30; l++) line_and_check(l, 1'b0, 1'b0, "R7 window");
    start_field(1'b0, 1'b0, 1'b1);
    for (int l = 1; l <= 25; l++) line_and_check(l, 1'b0, 1'b0, "R2 restart numbering");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_field(1'b1, 1'b0, 312, "R4 R5 PAL even");
    t_field(1'b1, 1'b1, 313, "R4 R6 PAL odd");
    t_field(1'b0, 1'b0, 262, "R7 plain window");
    t_latch();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end
endmodule